// File: doc/BRIEF.md
# Load/Store-Multiple Micro-Op Sequencer

This block turns one block-transfer instruction (load several registers from consecutive words, or store several registers to them) into a stream of simple micro-operations, issued one per accepted cycle. The caller presents a 16-bit register list, a base register index and mode flags: load or store, increment or decrement, address step before or after, base writeback, and the user-bank or exception-return form. The block then emits one descriptor per handshake. Each descriptor has an operation code, a destination register, a source register, an 8-bit immediate and three flags: control transfer, return, and end of sequence.

The sequence first copies the base into a scratch register. Every memory micro-op then uses that scratch register as its address. The base is only updated after the final memory access. For a load with writeback, the last loaded value waits in a second scratch register until the base has been updated. A fault on any memory micro-op therefore leaves the base register unmodified.

Top module: `lsm_uop_seq`

## Requirements
- R1: `in_ready` is high exactly when no sequence is in progress. The first micro-op is presented the cycle after acceptance. While `uop_valid` is high and `uop_ready` is low, every descriptor output holds its value.
- R2: With n set bits in the list, a sequence has 1 + n micro-ops, plus 2 more for a load with writeback or 1 more for a store with writeback. An empty list yields exactly one micro-op.
- R3: The first micro-op is op 0 (add immediate) with destination scratch register 32, source equal to the base index and immediate 0.
- R4: Memory micro-ops visit listed registers in ascending index order. They use op 2 (load) or op 3 (store), with source 32. The data register goes in the destination field. The immediate is start + 4k for the k-th register (two's complement). The start value is 0 for increment-after, 4 for increment-before, 4 - 4n for decrement-after and -4n for decrement-before.
- R5: For a load with writeback, the highest listed register is loaded into scratch register 33 instead of its own register.
- R6: With writeback and a non-empty list, one micro-op follows all memory micro-ops. It is op 0 (increment) or op 1 (decrement), with destination and source both the base index and immediate 4n.
- R7: For a load with writeback, a move from 33 into the highest listed register follows the base update. This move is op 4. In the exception-return form with register 15 it is op 5, a move that also restores status.
- R8: If the user flag is set and register 15 is not listed, data registers are coded 16 + index; the base is never remapped. If the user flag is set and register 15 is listed, a direct load into 15 uses op 6, a load that also restores status.
- R9: An op-4 move into register 15 sets the control flag. If the base is 13, it also sets the return flag. No other micro-op sets either flag.
- R10: Only the final micro-op carries the last flag. After it is accepted, the block is idle the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction accepted |
| in_list | input | 16 | Register list, bit i = register i |
| in_base | input | 4 | Base register index |
| in_load | input | 1 | 1 = load, 0 = store |
| in_up | input | 1 | 1 = increment, 0 = decrement |
| in_pre | input | 1 | 1 = step address before access |
| in_wb | input | 1 | Base writeback |
| in_user | input | 1 | User-bank / exception-return form |
| uop_valid | output | 1 | Descriptor valid |
| uop_ready | input | 1 | Pipeline takes descriptor |
| uop_op | output | 3 | Operation code |
| uop_dst | output | 6 | Destination (or store data) register |
| uop_src | output | 6 | Source / address register |
| uop_imm | output | 8 | Immediate or byte offset |
| uop_ctrl | output | 1 | Indirect control transfer |
| uop_ret | output | 1 | Return |
| uop_last | output | 1 | Final micro-op of the sequence |

## Verification
The first descriptor is due one cycle after the accepting edge. Each later descriptor is due one cycle after the edge on which the previous one was taken. The idle state returns one cycle after the edge that takes the last descriptor. The bench drives and samples on the falling edge. Right after the accepting edge it expects the copy micro-op; after each edge with `uop_ready` high it expects the next entry of its own computed list. During stalls it compares the outputs with the values seen one cycle earlier. Once the list is exhausted it checks one more falling edge for `uop_valid` low and `in_ready` high.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int NREG      = 16;
  localparam int IDX_W     = $clog2(NREG);
  localparam int REG_W     = 6;
  localparam int IMM_W     = 8;
  localparam int CNT_W     = $clog2(NREG + 4);
  localparam int USER_BANK = 16;

  localparam logic [REG_W-1:0] REG_T0 = REG_W'(32);
  localparam logic [REG_W-1:0] REG_T1 = REG_W'(33);
  localparam logic [IDX_W-1:0] IDX_PC = IDX_W'(15);
  localparam logic [IDX_W-1:0] IDX_SP = IDX_W'(13);

  typedef enum logic [2:0] {
    OP_ADDI   = 3'd0,
    OP_SUBI   = 3'd1,
    OP_LOAD   = 3'd2,
    OP_STORE  = 3'd3,
    OP_MOV    = 3'd4,
    OP_MOVRET = 3'd5,
    OP_LDRET  = 3'd6
  } uop_op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_COPY, PH_MEM, PH_WB, PH_MOVE
  } phase_e;

  typedef struct packed {
    logic [IDX_W-1:0] base;
    logic             load;
    logic             up;
    logic             pre;
    logic             wb;
    logic             user;
    logic             has_pc;
    logic [CNT_W-1:0] n;
    logic [IDX_W-1:0] last_reg;
  } cfg_t;

  typedef struct packed {
    uop_op_e          op;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
    logic [IMM_W-1:0] imm;
    logic             ctrl;
    logic             ret;
    logic             last;
  } uop_t;

  function automatic logic [CNT_W-1:0] count_ones(input logic [NREG-1:0] l);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CNT_W'(l[i]);
    return c;
  endfunction

  function automatic logic [IDX_W-1:0] highest_set(input logic [NREG-1:0] l);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < NREG; i++) if (l[i]) h = IDX_W'(i);
    return h;
  endfunction

  function automatic logic [CNT_W-1:0] uop_total(input logic [CNT_W-1:0] n,
                                                 input logic load, input logic wb);
    logic [CNT_W-1:0] t;
    if (n == '0) return CNT_W'(1);
    t = n + CNT_W'(1);
    if (wb) t = t + (load ? CNT_W'(2) : CNT_W'(1));
    return t;
  endfunction

  function automatic logic [IMM_W-1:0] start_offset(input logic [CNT_W-1:0] n,
                                                    input logic up, input logic pre);
    logic [IMM_W-1:0] span;
    span = IMM_W'({n, 2'b00});
    if (up) return pre ? IMM_W'(4) : IMM_W'(0);
    return pre ? (IMM_W'(0) - span) : (IMM_W'(4) - span);
  endfunction

  function automatic logic [REG_W-1:0] map_reg(input logic [IDX_W-1:0] idx,
                                               input logic to_user);
    return to_user ? (REG_W'(idx) + REG_W'(USER_BANK)) : REG_W'(idx);
  endfunction
endpackage

// File: rtl/lsm_low_pick.sv
module lsm_low_pick #(
  parameter int N = 16,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] mask,
  output logic [W-1:0] idx,
  output logic         any,
  output logic         single
);
  logic [N-1:0] low;

  assign low    = mask & (~mask + N'(1));
  assign any    = |mask;
  assign single = any && ((mask & ~low) == '0);

  generate
    for (genvar b = 0; b < W; b++) begin : g_enc
      logic [N-1:0] sel;
      for (genvar i = 0; i < N; i++) begin : g_bit
        localparam bit HIT = ((i >> b) & 1) == 1;
        assign sel[i] = HIT & low[i];
      end
      assign idx[b] = |sel;
    end
  endgenerate
endmodule

// File: rtl/lsm_uop_build.sv
module lsm_uop_build
  import lsm_pkg::*;
(
  input  phase_e           phase,
  input  cfg_t             cfg,
  input  logic [IDX_W-1:0] pick,
  input  logic             pick_single,
  input  logic [CNT_W-1:0] k,
  output uop_t             uop
);
  logic             force_user;
  logic             exc_ret;
  logic             mem_last;
  logic [IMM_W-1:0] offset;
  logic [REG_W-1:0] data_reg;
  logic [REG_W-1:0] move_reg;
  logic             move_to_pc;

  assign force_user = cfg.user & ~cfg.has_pc;
  assign exc_ret    = cfg.user & cfg.has_pc;
  assign mem_last   = pick_single;
  assign offset     = start_offset(cfg.n, cfg.up, cfg.pre) + IMM_W'({k, 2'b00});
  assign data_reg   = map_reg(pick, force_user);
  assign move_reg   = map_reg(cfg.last_reg, force_user);
  assign move_to_pc = (cfg.last_reg == IDX_PC);

  always_comb begin
    uop = '0;
    unique case (phase)
      PH_COPY: begin
        uop.op   = OP_ADDI;
        uop.dst  = REG_T0;
        uop.src  = REG_W'(cfg.base);
        uop.last = (cfg.n == '0);
      end
      PH_MEM: begin
        uop.src  = REG_T0;
        uop.imm  = offset;
        uop.dst  = data_reg;
        uop.last = mem_last & ~cfg.wb;
        if (!cfg.load)                      uop.op = OP_STORE;
        else if (cfg.wb && mem_last) begin
          uop.op  = OP_LOAD;
          uop.dst = REG_T1;
        end
        else if (pick == IDX_PC && exc_ret) uop.op = OP_LDRET;
        else                                uop.op = OP_LOAD;
      end
      PH_WB: begin
        uop.op   = cfg.up ? OP_ADDI : OP_SUBI;
        uop.dst  = REG_W'(cfg.base);
        uop.src  = REG_W'(cfg.base);
        uop.imm  = IMM_W'({cfg.n, 2'b00});
        uop.last = ~cfg.load;
      end
      PH_MOVE: begin
        uop.dst  = move_reg;
        uop.src  = REG_T1;
        uop.last = 1'b1;
        if (move_to_pc && exc_ret) uop.op = OP_MOVRET;
        else begin
          uop.op   = OP_MOV;
          uop.ctrl = move_to_pc;
          uop.ret  = move_to_pc && (cfg.base == IDX_SP);
        end
      end
      default: uop = '0;
    endcase
  end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
  import lsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NREG-1:0]  in_list,
  input  logic [IDX_W-1:0] in_base,
  input  logic             in_load,
  input  logic             in_up,
  input  logic             in_pre,
  input  logic             in_wb,
  input  logic             in_user,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic [2:0]       uop_op,
  output logic [REG_W-1:0] uop_dst,
  output logic [REG_W-1:0] uop_src,
  output logic [IMM_W-1:0] uop_imm,
  output logic             uop_ctrl,
  output logic             uop_ret,
  output logic             uop_last
);
  phase_e           phase;
  cfg_t             cfg;
  cfg_t             new_cfg;
  logic [NREG-1:0]  mask;
  logic [CNT_W-1:0] k;
  logic [CNT_W-1:0] issued;
  logic [IDX_W-1:0] pick;
  logic             pick_any;
  logic             pick_single;
  uop_t             uop;

  logic accept;
  logic fire;
  logic done;

  assign in_ready  = (phase == PH_IDLE);
  assign uop_valid = (phase != PH_IDLE);
  assign accept    = in_valid & in_ready;
  assign fire      = uop_valid & uop_ready;
  assign done      = fire & uop.last;

  always_comb begin
    new_cfg          = '0;
    new_cfg.base     = in_base;
    new_cfg.load     = in_load;
    new_cfg.up       = in_up;
    new_cfg.pre      = in_pre;
    new_cfg.wb       = in_wb;
    new_cfg.user     = in_user;
    new_cfg.has_pc   = in_list[IDX_PC];
    new_cfg.n        = count_ones(in_list);
    new_cfg.last_reg = highest_set(in_list);
  end

  lsm_low_pick #(.N(NREG), .W(IDX_W)) u_pick (
    .mask   (mask),
    .idx    (pick),
    .any    (pick_any),
    .single (pick_single)
  );

  lsm_uop_build u_build (
    .phase       (phase),
    .cfg         (cfg),
    .pick        (pick),
    .pick_single (pick_single),
    .k           (k),
    .uop         (uop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cfg    <= '0;
      mask   <= '0;
      k      <= '0;
      issued <= '0;
    end else if (accept) begin
      phase  <= PH_COPY;
      cfg    <= new_cfg;
      mask   <= in_list;
      k      <= '0;
      issued <= '0;
    end else if (fire) begin
      issued <= issued + CNT_W'(1);
      unique case (phase)
        PH_COPY: phase <= (cfg.n == '0) ? PH_IDLE : PH_MEM;
        PH_MEM: begin
          mask <= mask & (mask - NREG'(1));
          k    <= k + CNT_W'(1);
          if (pick_single) phase <= cfg.wb ? PH_WB : PH_IDLE;
        end
        PH_WB:   phase <= cfg.load ? PH_MOVE : PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign uop_op   = uop.op;
  assign uop_dst  = uop.dst;
  assign uop_src  = uop.src;
  assign uop_imm  = uop.imm;
  assign uop_ctrl = uop.ctrl;
  assign uop_ret  = uop.ret;
  assign uop_last = uop.last;

  a_r1_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop));

  a_r2_total_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> CNT_W'(issued + CNT_W'(1)) == uop_total(cfg.n, cfg.load, cfg.wb));

  a_r3_copy_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> uop.op == OP_ADDI && uop.dst == REG_T0 && uop.imm == '0
               && uop.src == REG_W'($past(in_base)));

  a_r4_mem_has_reg: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && phase == PH_MEM |-> pick_any && uop.src == REG_T0);

  a_r6_update_then_move: assert property (@(posedge clk) disable iff (!rst_n)
    fire && phase == PH_WB |=> !uop_valid || uop.op == OP_MOV || uop.op == OP_MOVRET);

  a_r9_ret_needs_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop.ret |-> uop.ctrl && uop.dst == REG_W'(IDX_PC));

  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !uop_valid && in_ready);
endmodule

// File: tb/lsm_uop_seq_test.sv
module lsm_uop_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_list = '0;
  logic [3:0] in_base = '0;
  logic in_load = 0, in_up = 0, in_pre = 0, in_wb = 0, in_user = 0;
  logic uop_valid;
  logic uop_ready = 1'b0;
  logic [2:0] uop_op;
  logic [5:0] uop_dst, uop_src;
  logic [7:0] uop_imm;
  logic uop_ctrl, uop_ret, uop_last;

  always #4 clk = ~clk;

  lsm_uop_seq uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_list(in_list), .in_base(in_base), .in_load(in_load), .in_up(in_up),
    .in_pre(in_pre), .in_wb(in_wb), .in_user(in_user),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
    .uop_dst(uop_dst), .uop_src(uop_src), .uop_imm(uop_imm),
    .uop_ctrl(uop_ctrl), .uop_ret(uop_ret), .uop_last(uop_last)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int stall_ctr = 0;
  bit finished = 0;

  logic [2:0] e_op [0:19];
  logic [5:0] e_dst [0:19];
  logic [5:0] e_src [0:19];
  logic [7:0] e_imm [0:19];
  logic       e_ctrl [0:19];
  logic       e_ret [0:19];
  logic       e_last [0:19];
  string      e_tag [0:19];
  int         e_cnt;

  function automatic logic [25:0] pack_out();
    return {uop_op, uop_dst, uop_src, uop_imm, uop_ctrl, uop_ret, uop_last};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h list=%h base=%0d ld=%0d up=%0d pre=%0d wb=%0d usr=%0d",
               tag, got, exp, in_list, in_base, in_load, in_up, in_pre, in_wb, in_user);
    end
  endtask

  task automatic push(input int op, input int dst, input int src, input int imm,
                      input bit c, input bit r, input string tag);
    e_op[e_cnt]   = 3'(op);
    e_dst[e_cnt]  = 6'(dst);
    e_src[e_cnt]  = 6'(src);
    e_imm[e_cnt]  = 8'(imm);
    e_ctrl[e_cnt] = c;
    e_ret[e_cnt]  = r;
    e_last[e_cnt] = 1'b0;
    e_tag[e_cnt]  = tag;
    e_cnt++;
  endtask

  task automatic build(input logic [15:0] l, input int b, input bit ld, input bit up,
                       input bit pre, input bit wb, input bit usr);
    int n, start, seen, lastr, data;
    bit fu, er;
    e_cnt = 0;
    n = 0;
    for (int r = 0; r < 16; r++) if (l[r]) n++;
    fu = usr && !l[15];
    er = usr && l[15];
    push(0, 32, b, 0, 0, 0, "R3");
    if (up) start = pre ? 4 : 0;
    else    start = pre ? -4 * n : 4 - 4 * n;
    seen = 0;
    lastr = 0;
    for (int r = 0; r < 16; r++) begin
      if (l[r]) begin
        data = fu ? r + 16 : r;
        if (!ld)                     push(3, data, 32, start + 4 * seen, 0, 0, fu ? "R8" : "R4");
        else if (wb && seen == n-1)  push(2, 33, 32, start + 4 * seen, 0, 0, "R5");
        else if (r == 15 && er)      push(6, data, 32, start + 4 * seen, 0, 0, "R8");
        else                         push(2, data, 32, start + 4 * seen, 0, 0, fu ? "R8" : "R4");
        seen++;
        lastr = r;
      end
    end
    if (wb && n > 0) begin
      push(up ? 0 : 1, b, b, 4 * n, 0, 0, "R6");
      if (ld) begin
        data = fu ? lastr + 16 : lastr;
        if (lastr == 15 && er) push(5, data, 33, 0, 0, 0, "R7");
        else push(4, data, 33, 0, lastr == 15, lastr == 15 && b == 13,
                  lastr == 15 ? "R9" : "R7");
      end
    end
    e_last[e_cnt-1] = 1'b1;
  endtask

  task automatic run_one(input logic [15:0] l, input int b, input bit ld, input bit up,
                         input bit pre, input bit wb, input bit usr);
    int idx;
    bit stalled;
    logic [25:0] held, expv;
    build(l, b, ld, up, pre, wb, usr);
    @(negedge clk);
    check(in_ready === 1'b1 && uop_valid === 1'b0, "R1 idle before issue",
          {30'd0, in_ready, uop_valid}, 32'd2);
    in_list = l; in_base = 4'(b); in_load = ld; in_up = up; in_pre = pre;
    in_wb = wb; in_user = usr; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    idx = 0;
    stalled = 0;
    held = '0;
    while (idx < e_cnt) begin
      if (stalled)
        check(uop_valid === 1'b1 && pack_out() === held, "R1 hold on stall",
              32'(pack_out()), 32'(held));
      if (uop_valid !== 1'b1 || in_ready !== 1'b0) begin
        check(1'b0, "R1 valid during sequence", {30'd0, uop_valid, in_ready}, 32'd2);
        break;
      end
      stall_ctr++;
      uop_ready = ((stall_ctr % 5) != 2) && ((stall_ctr % 7) != 3);
      if (uop_ready) begin
        expv = {e_op[idx], e_dst[idx], e_src[idx], e_imm[idx], e_ctrl[idx], e_ret[idx], e_last[idx]};
        check(pack_out() === expv, e_tag[idx], 32'(pack_out()), 32'(expv));
        idx++;
        stalled = 0;
      end else begin
        held = pack_out();
        stalled = 1;
      end
      @(posedge clk);
      @(negedge clk);
    end
    uop_ready = 1'b0;
    check(uop_valid === 1'b0 && in_ready === 1'b1, "R2 R10 sequence ends after last",
          {30'd0, uop_valid, in_ready}, 32'd1);
  endtask

  function automatic logic [15:0] list_sel(input int j);
    if (j < 16) return 16'(1) << j;
    case (j)
      16: return 16'h0000;
      17: return 16'hFFFF;
      18: return 16'h8001;
      19: return 16'h2005;
      20: return 16'hA0F0;
      21: return 16'h7FFE;
      22: return 16'h00FF;
      default: return 16'hC003;
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready === 1'b1 && uop_valid === 1'b0, "R1 reset state",
          {30'd0, in_ready, uop_valid}, 32'd2);
    rst_n = 1'b1;
    for (int j = 0; j < 24; j++)
      for (int f = 0; f < 32; f++)
        for (int bs = 0; bs < 2; bs++)
          run_one(list_sel(j), bs ? 13 : 2, f[0], f[1], f[2], f[3], f[4]);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog got=%0d exp=<190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule